// File: doc/BRIEF.md
# Byte-Wide Electrically Erasable Memory Control Logic

This block is a synthesizable model of the control logic inside a byte-wide, many-time-programmable, electrically erasable memory. Each cycle it decodes chip select, output enable and a program/erase strobe, together with two qualifier inputs. One qualifier reports high voltage on the programming supply pin and the other reports high voltage on address bit 9. From these inputs it picks one of these operations: read, output disable, standby, byte program, chip erase, program/erase inhibit, or hardware identification. The storage is a parameterised register array. The data bus is split into an input byte, an output byte and a drive-enable flag.

Programming can only clear bits. A byte program writes the AND of the stored byte and the presented data. The only way back to ones is a whole-array erase. Each write takes place once, on the clock edge at which the strobe is first seen low. Reads and identification bytes are combinational from the current inputs. A write becomes visible in the cycle after the edge that performed it. The programming qualifier, the bit-9 qualifier, the strobe and the data input are plain control and data pins, so no valid/ready handshake applies.

Top module: `flash_mtp_ctl`

## Requirements
- R1: `bus_oe` is 1 only when `ce_n`=0 and `oe_n`=0 and the two qualifiers are not both set. In every other input combination it is 0.
- R2: With `ce_n`=1 the bus is not driven. A strobe falling edge has no effect on the array, whether or not either qualifier is set.
- R3: With `ce_n`=0, `oe_n`=0 and `hv_a9`=0, `bus_out` equals the byte stored at `addr` in the same cycle. This holds whether `hv_supply` is 0 or 1.
- R4: With `hv_supply`=1, `hv_a9`=0, `ce_n`=0 and `oe_n`=1, a falling `pgm_n` changes the byte at `addr` to (old byte AND `din`). The new value is readable in the cycle after the clock edge that sampled `pgm_n` low.
- R5: A program operation never turns a 0 bit into 1.
- R6: With both qualifiers set, `ce_n`=0 and `oe_n`=1, a falling `pgm_n` sets every byte to 0xFF. The values of `addr` and `din` do not matter.
- R7: With `hv_a9`=1, `hv_supply`=0, `ce_n`=0 and `oe_n`=0, and with the upper address bits held at 0, `bus_out` is 0xBF when `addr[0]`=0 and 0xA5 when `addr[0]`=1.
- R8: Holding `pgm_n` low for more than one cycle gives only one write. Later changes to `din` while the strobe stays low are not applied.
- R9: After reset every byte reads 0xFF.
- R10: A falling `pgm_n` in read, output-disable or identification mode leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the array with 0xFF |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program/erase strobe |
| hv_supply | input | 1 | Programming supply is at high voltage |
| hv_a9 | input | 1 | Address bit 9 is at high voltage |
| addr | input | AW (8) | Byte address |
| din | input | DW (8) | Data presented for programming |
| bus_out | output | DW (8) | Data presented for output |
| bus_oe | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The hardest situation to reach is a byte that is programmed several times before an erase. Only in that case does the AND accumulation show, and only there can a wrongly set bit be seen. The random stimulus therefore restricts most addresses to a small window so that the same bytes are rewritten often. The other hard cases are a strobe held low while `din` changes, and strobe edges that arrive with chip select high or output enable low. These cases are reached with directed sequences, and each one is followed by a read-back through the normal read mode.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_READ,
    MD_OUTDIS,
    MD_PROGRAM,
    MD_ERASE,
    MD_IDENT
  } op_mode_e;
endpackage

// File: rtl/flash_mode_dec.sv
module flash_mode_dec
  import flash_ctl_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     hv_supply,
  input  logic     hv_a9,
  output op_mode_e mode
);
  always_comb begin
    if (ce_n) begin
      mode = (hv_supply || hv_a9) ? MD_INHIBIT : MD_STANDBY;
    end else if (hv_supply && hv_a9) begin
      mode = oe_n ? MD_ERASE : MD_OUTDIS;
    end else if (hv_supply) begin
      mode = oe_n ? MD_PROGRAM : MD_READ;
    end else if (hv_a9) begin
      mode = oe_n ? MD_OUTDIS : MD_IDENT;
    end else begin
      mode = oe_n ? MD_OUTDIS : MD_READ;
    end
  end
endmodule

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  output logic fall
);
  logic pgm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  assign fall = pgm_q && !pgm_n;

  AST_ONE_SHOT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R8
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic          erase_we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   mem_q[g] <= ERASED;
      else if (erase_we)                            mem_q[g] <= ERASED;
      else if (prog_we && waddr == AW'(g))          mem_q[g] <= mem_q[g] & wdata;
    end

    AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_we && !erase_we && waddr == AW'(g)) |=> ((mem_q[g] & ~$past(mem_q[g])) == '0)); // R5
    AST_ERASE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      erase_we |=> (mem_q[g] == ERASED)); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_we && !erase_we) |=> $stable(mem_q[g])); // R10
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/flash_mtp_ctl.sv
module flash_mtp_ctl
  import flash_ctl_pkg::*;
#(
  parameter int            DEPTH  = 256,
  parameter int            DW     = 8,
  parameter logic [DW-1:0] ID_MFR = 8'hBF,
  parameter logic [DW-1:0] ID_DEV = 8'hA5,
  localparam int           AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          pgm_n,
  input  logic          hv_supply,
  input  logic          hv_a9,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe
);
  op_mode_e      mode;
  logic          strobe_fall;
  logic [DW-1:0] cell_data;

  flash_mode_dec u_dec (
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .hv_supply (hv_supply),
    .hv_a9     (hv_a9),
    .mode      (mode)
  );

  flash_strobe_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pgm_n (pgm_n),
    .fall  (strobe_fall)
  );

  flash_cell_array #(.DEPTH(DEPTH), .DW(DW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_we  (strobe_fall && mode == MD_PROGRAM),
    .erase_we (strobe_fall && mode == MD_ERASE),
    .waddr    (addr),
    .wdata    (din),
    .raddr    (addr),
    .rdata    (cell_data)
  );

  always_comb begin
    bus_oe  = 1'b0;
    bus_out = '0;
    unique case (mode)
      MD_READ:  begin bus_oe = 1'b1; bus_out = cell_data; end
      MD_IDENT: begin bus_oe = 1'b1; bus_out = addr[0] ? ID_DEV : ID_MFR; end
      default:  ;
    endcase
  end

  AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!ce_n && !oe_n)); // R1
  AST_STANDBY_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !bus_oe); // R2
  AST_ID_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && hv_a9 && !hv_supply) |-> (bus_oe && (bus_out == ID_MFR || bus_out == ID_DEV))); // R7
endmodule

// File: tb/flash_mtp_ctl_tb_top.sv
module flash_mtp_ctl_tb_top;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
  logic          hv_supply = 1'b0, hv_a9 = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    bus_out;
  logic          bus_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  flash_mtp_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .hv_supply(hv_supply), .hv_a9(hv_a9), .addr(addr), .din(din),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_drive(logic c, logic o, logic s, logic a);
    return !c && !o && !(s && a);
  endfunction

  function automatic logic [7:0] exp_data(logic s, logic a, logic [AW-1:0] ad);
    if (a && !s) return ad[0] ? 8'hA5 : 8'hBF;
    return model[ad];
  endfunction

  task automatic apply_write(logic c, logic o, logic s, logic a, logic [AW-1:0] ad, logic [7:0] d);
    if (!c && o && s && a) begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    end else if (!c && o && s && !a) begin
      model[ad] = model[ad] & d;
    end
  endtask

  task automatic drive(logic c, logic o, logic p, logic s, logic a, logic [AW-1:0] ad, logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; hv_supply = s; hv_a9 = a; addr = ad; din = d;
    #1;
  endtask

  task automatic pulse(string req, logic c, logic o, logic s, logic a, logic [AW-1:0] ad, logic [7:0] d);
    drive(c, o, 1'b1, s, a, ad, d);
    chk(req, {7'd0, bus_oe}, {7'd0, exp_drive(c, o, s, a)});
    drive(c, o, 1'b0, s, a, ad, d);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, ad, d);
    apply_write(c, o, s, a, ad, d);
  endtask

  task automatic rd(string req, logic [AW-1:0] ad);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, ad, 8'h00);
    chk(req, {7'd0, bus_oe}, 8'd1);
    chk(req, bus_out, model[ad]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    #1 chk("R2 reset standby", {7'd0, bus_oe}, 8'd0);
    rst_n = 1'b1;

    // R9: erased after reset
    rd("R9", 8'h00); rd("R9", 8'hFF); rd("R9", 8'h3C);

    // R4 / R5: program and reprogram same byte
    pulse("R4", 0, 1, 1, 0, 8'h10, 8'hF0); rd("R4", 8'h10);
    pulse("R5", 0, 1, 1, 0, 8'h10, 8'h3F); rd("R5", 8'h10);
    chk("R5 and", model[8'h10], 8'h30);

    // R3: read with supply flag set (verify)
    drive(0, 0, 1, 1, 0, 8'h10, 8'h00);
    chk("R3 verify", bus_out, 8'h30);

    // R7: identification
    drive(0, 0, 1, 0, 1, 8'h00, 8'h00); chk("R7 mfr", bus_out, 8'hBF); chk("R7 oe", {7'd0, bus_oe}, 8'd1);
    drive(0, 0, 1, 0, 1, 8'h01, 8'h00); chk("R7 dev", bus_out, 8'hA5);
    // R1: both flags, oe low: no drive; oe high: no drive
    drive(0, 0, 1, 1, 1, 8'h01, 8'h00); chk("R1 both flags", {7'd0, bus_oe}, 8'd0);
    drive(0, 1, 1, 0, 0, 8'h01, 8'h00); chk("R1 oe high", {7'd0, bus_oe}, 8'd0);

    // R2: inhibit with strobe edge
    pulse("R2", 1, 1, 1, 0, 8'h20, 8'h00);
    pulse("R2", 1, 1, 1, 1, 8'h20, 8'h00);
    rd("R2", 8'h20); rd("R2", 8'h10);

    // R10: strobe in read/outdis/ident modes
    pulse("R10", 0, 0, 1, 0, 8'h21, 8'h00);
    pulse("R10", 0, 1, 0, 0, 8'h21, 8'h00);
    pulse("R10", 0, 0, 0, 1, 8'h21, 8'h00);
    rd("R10", 8'h21);

    // R8: hold strobe low while din changes
    drive(0, 1, 1, 1, 0, 8'h05, 8'hF0);
    drive(0, 1, 0, 1, 0, 8'h05, 8'hF0);
    drive(0, 1, 0, 1, 0, 8'h05, 8'h0F);
    drive(0, 1, 0, 1, 0, 8'h05, 8'h00);
    drive(1, 1, 1, 0, 0, 8'h05, 8'h00);
    model[8'h05] = model[8'h05] & 8'hF0;
    rd("R8", 8'h05);

    // R6: erase ignores addr/din
    pulse("R6", 0, 1, 1, 1, 8'h77, 8'h00);
    rd("R6", 8'h10); rd("R6", 8'h05); rd("R6", 8'h77);

    // random mix, small address window for repeats
    for (int n = 0; n < 600; n++) begin
      logic c, o, s, a;
      logic [AW-1:0] ad;
      logic [7:0] d;
      c = ($urandom % 5) == 0;
      o = ($urandom % 3) != 0;
      s = ($urandom % 4) != 0;
      a = ($urandom % 12) == 0;
      ad = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 16);
      d = 8'($urandom);
      drive(c, !o, 1'b1, s, a, ad, d);
      chk("R1 rand", {7'd0, bus_oe}, {7'd0, exp_drive(c, !o, s, a)});
      if (exp_drive(c, !o, s, a)) chk("R3/R7 rand", bus_out, exp_data(s, a, ad));
      pulse("R4/R6 rand", c, o, s, a, ad, d);
      rd("R5 rand", AW'($urandom % 16));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule